// File: doc/BRIEF.md
# TLB Entry Low Register Pair

This block holds the two 64-bit staging registers that carry the low half of a translation entry: one for the even page of a pair and one for the odd page. Software reaches them through a coprocessor-style port, using one select bit to pick a register for a write and another select bit to pick one for a read. The TLB side gets a write bundle that shows both registers and a single merged global bit. It can also load both registers at once when an entry is read back out of the TLB.

Each register has fixed field positions, which the TLB and software depend on. Bit 63 inhibits reads. Bit 62 inhibits execution. Bits 61..55 are fill. Bits 54..30 extend the frame number. Bits 29..6 hold the frame number. Bits 5..3 give the cache attribute. Bit 2 is dirty, bit 1 is valid and bit 0 is global.

Three feature-enable inputs control which fields take a software write. They gate the read-inhibit bit, the execute-inhibit bit and the frame-number extension. The fill bits are never stored.

Top module: `tlbpair_top`

## Requirements
- R1: After a synchronous reset, both registers read as all zeros, and the merged global output is 0.
- R2: A software write with `sw_sel`=0 updates only the even register, and with `sw_sel`=1 only the odd register. The other register keeps its value.
- R3: Fill bits 61..55 ignore every write and every TLB load, and always read as zero on every output.
- R4: Bit 63 (read-inhibit) takes the written value only while `rd_inh_en`=1. A software write made while `rd_inh_en`=0 stores 0 in that bit.
- R5: Bit 62 (execute-inhibit) takes the written value only while `ex_inh_en`=1. A software write made while `ex_inh_en`=0 stores 0 in that bit.
- R6: While `lpa_en`=0, a software write leaves the stored bits 54..30 unchanged. While `lpa_en`=0, those bits read as zero on all outputs. When `lpa_en` returns to 1, the stored value is visible again.
- R7: The frame number (29..6), cache attribute (5..3), dirty (2), valid (1) and global (0) bits store the written value as given.
- R8: `tlbw_glob` is the AND of bit 0 of the two registers. `tlbw_even` and `tlbw_odd` show the registers as they read.
- R9: A pulse on `tlbr_load` loads `tlbr_even` into the even register and `tlbr_odd` into the odd register. Bit 0 of both registers is set to `tlbr_glob`, whatever bit 0 of the loaded data is. The same fill and extension rules as for writes apply.
- R10: When `sw_we` and `tlbr_load` are both high in the same cycle, the TLB load decides the contents of both registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_inh_en | input | 1 | Allows software to write bit 63 |
| ex_inh_en | input | 1 | Allows software to write bit 62 |
| lpa_en | input | 1 | Enables the frame-number extension bits 54..30 |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 1 | Write target: 0 even, 1 odd |
| sw_wdata | input | 64 | Software write data |
| sw_rsel | input | 1 | Read source: 0 even, 1 odd |
| sw_rdata | output | 64 | Read view of the selected register |
| tlbw_even | output | 64 | Even register as presented to a TLB write |
| tlbw_odd | output | 64 | Odd register as presented to a TLB write |
| tlbw_glob | output | 1 | Merged global bit for a TLB write |
| tlbr_load | input | 1 | Loads both registers from a TLB read |
| tlbr_even | input | 64 | Even-page data from the TLB |
| tlbr_odd | input | 64 | Odd-page data from the TLB |
| tlbr_glob | input | 1 | Single global bit of the TLB entry |

## Verification
A software write or a TLB load lands at the next rising edge. The bench drives it on a falling edge and checks the read port one full cycle later, on the following falling edge. The read port, the write bundle and the merged global bit are combinational from the stored state and the enables. So a change to `sw_rsel` or `lpa_en` is checked a short delay later within the same half cycle, with no clock edge between. Every check samples on the falling edge or shortly after it, never on the rising edge.

// File: rtl/tlbpair_pkg.sv
package tlbpair_pkg;

    localparam int WORD_W = 64;
    localparam int PFNX_W = 25;
    localparam int PFN_W  = 24;
    localparam int CA_W   = 3;
    localparam int FILL_W = WORD_W - 2 - PFNX_W - PFN_W - CA_W - 3;
    localparam int NREG   = 2;

    typedef struct packed {
        logic              rd_inh;
        logic              ex_inh;
        logic [FILL_W-1:0] fill;
        logic [PFNX_W-1:0] pfn_ext;
        logic [PFN_W-1:0]  pfn;
        logic [CA_W-1:0]   cattr;
        logic              dirty;
        logic              valid;
        logic              glob;
    } pte_lo_t;

    // Value stored after a software write, given the current content.
    function automatic pte_lo_t sw_merge(pte_lo_t old, pte_lo_t wr,
                                         logic ri_en, logic xi_en, logic lpa);
        pte_lo_t n;
        n         = wr;
        n.rd_inh  = ri_en ? wr.rd_inh : 1'b0;
        n.ex_inh  = xi_en ? wr.ex_inh : 1'b0;
        n.fill    = '0;
        n.pfn_ext = lpa ? wr.pfn_ext : old.pfn_ext;
        return n;
    endfunction

    // Value stored when the TLB read path loads a register.
    function automatic pte_lo_t tlb_merge(pte_lo_t old, pte_lo_t ld,
                                          logic g, logic lpa);
        pte_lo_t n;
        n         = ld;
        n.fill    = '0;
        n.glob    = g;
        n.pfn_ext = lpa ? ld.pfn_ext : old.pfn_ext;
        return n;
    endfunction

    // Externally visible form of a stored register.
    function automatic pte_lo_t read_view(pte_lo_t q, logic lpa);
        pte_lo_t v;
        v      = q;
        v.fill = '0;
        if (!lpa) v.pfn_ext = '0;
        return v;
    endfunction

endpackage

// File: rtl/tlbpair_reg.sv
module tlbpair_reg
    import tlbpair_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  pte_lo_t wr_word,
    input  logic    ld_en,
    input  pte_lo_t ld_word,
    input  logic    ld_glob,
    input  logic    ri_en,
    input  logic    xi_en,
    input  logic    lpa,
    output pte_lo_t q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (ld_en)
            q <= tlb_merge(q, ld_word, ld_glob, lpa);
        else if (wr_en)
            q <= sw_merge(q, wr_word, ri_en, xi_en, lpa);
    end

    a_r4_ri_gated: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ld_en && !ri_en) |=> !q.rd_inh);

    a_r5_xi_gated: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ld_en && !xi_en) |=> !q.ex_inh);

    a_r6_ext_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ld_en && !lpa) |=> (q.pfn_ext == $past(q.pfn_ext)));

    a_r9_glob_load: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (q.glob == $past(ld_glob)));

    a_r3_fill_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en || ld_en) |=> (q.fill == '0));

endmodule

// File: rtl/tlbpair_view.sv
module tlbpair_view
    import tlbpair_pkg::*;
(
    input  pte_lo_t even_q,
    input  pte_lo_t odd_q,
    input  logic    lpa,
    input  logic    rsel,
    output pte_lo_t rd_view,
    output pte_lo_t w_even,
    output pte_lo_t w_odd,
    output logic    w_glob
);

    always_comb begin
        w_even  = read_view(even_q, lpa);
        w_odd   = read_view(odd_q, lpa);
        rd_view = rsel ? w_odd : w_even;
        w_glob  = even_q.glob & odd_q.glob;
    end

endmodule

// File: rtl/tlbpair_top.sv
module tlbpair_top
    import tlbpair_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_inh_en,
    input  logic              ex_inh_en,
    input  logic              lpa_en,
    input  logic              sw_we,
    input  logic              sw_sel,
    input  logic [WORD_W-1:0] sw_wdata,
    input  logic              sw_rsel,
    output logic [WORD_W-1:0] sw_rdata,
    output logic [WORD_W-1:0] tlbw_even,
    output logic [WORD_W-1:0] tlbw_odd,
    output logic              tlbw_glob,
    input  logic              tlbr_load,
    input  logic [WORD_W-1:0] tlbr_even,
    input  logic [WORD_W-1:0] tlbr_odd,
    input  logic              tlbr_glob
);

    pte_lo_t q   [NREG];
    pte_lo_t ldw [NREG];
    pte_lo_t rv, we_v, wo_v;

    assign ldw[0] = pte_lo_t'(tlbr_even);
    assign ldw[1] = pte_lo_t'(tlbr_odd);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        tlbpair_reg u_reg (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (sw_we && (sw_sel == 1'(i))),
            .wr_word (pte_lo_t'(sw_wdata)),
            .ld_en   (tlbr_load),
            .ld_word (ldw[i]),
            .ld_glob (tlbr_glob),
            .ri_en   (rd_inh_en),
            .xi_en   (ex_inh_en),
            .lpa     (lpa_en),
            .q       (q[i])
        );
    end

    tlbpair_view u_view (
        .even_q  (q[0]),
        .odd_q   (q[1]),
        .lpa     (lpa_en),
        .rsel    (sw_rsel),
        .rd_view (rv),
        .w_even  (we_v),
        .w_odd   (wo_v),
        .w_glob  (tlbw_glob)
    );

    assign sw_rdata  = rv;
    assign tlbw_even = we_v;
    assign tlbw_odd  = wo_v;

    a_r2_other_kept: assert property (@(posedge clk) disable iff (rst)
        (sw_we && !tlbr_load) |=> (q[!$past(sw_sel)] == $past(q[!sw_sel])));

    a_r8_glob_pair: assert property (@(posedge clk) disable iff (rst)
        tlbw_glob |-> (sw_rsel ? tlbw_odd[0] : tlbw_even[0]) && sw_rdata[0]);

    a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
        (tlbr_load && sw_we) |=> (q[0].glob == $past(tlbr_glob)) && (q[1].glob == $past(tlbr_glob)));

    a_r1_reset_zero: assert property (@(posedge clk)
        $past(rst) |-> (tlbw_even == '0) && (tlbw_odd == '0) && !tlbw_glob);

endmodule

// File: tb/tlbpair_top_test.sv
module tlbpair_top_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] FILL_M = 64'h3F80_0000_0000_0000;
    localparam logic [63:0] EXT_M  = 64'h007F_FFFF_C000_0000;

    logic clk = 0, rst = 1;
    logic rd_inh_en = 1, ex_inh_en = 1, lpa_en = 1;
    logic sw_we = 0, sw_sel = 0, sw_rsel = 0;
    logic [63:0] sw_wdata = '0, sw_rdata, tlbw_even, tlbw_odd;
    logic tlbw_glob;
    logic tlbr_load = 0, tlbr_glob = 0;
    logic [63:0] tlbr_even = '0, tlbr_odd = '0;

    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlbpair_top uut (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic sel, output logic [63:0] v);
        sw_rsel = sel; #1; v = sw_rdata;
    endtask

    task automatic wr(logic sel, logic [63:0] d);
        @(negedge clk); sw_we = 1; sw_sel = sel; sw_wdata = d;
        @(negedge clk); sw_we = 0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        @(negedge clk); rst = 0;
        rd(0, v); chk("R1 even", v, 0);
        rd(1, v); chk("R1 odd", v, 0);
        chk("R1 glob", 64'(tlbw_glob), 0);
    endtask

    task automatic t_select();
        logic [63:0] v;
        wr(0, '1);
        rd(0, v); chk("R2/R3/R7 even", v, ~FILL_M);
        rd(1, v); chk("R2 odd untouched", v, 0);
        wr(1, 64'h0000_0000_1234_5679);
        rd(1, v); chk("R7 odd fields", v, 64'h0000_0000_1234_5679);
        rd(0, v); chk("R2 even kept", v, ~FILL_M);
        chk("R3 tlbw fill", tlbw_even & FILL_M, 0);
    endtask

    task automatic t_inhibit();
        logic [63:0] v;
        rd_inh_en = 0; ex_inh_en = 1;
        wr(1, 64'hC000_0000_0000_0000);
        rd(1, v); chk("R4 ri forced", v, 64'h4000_0000_0000_0000);
        rd_inh_en = 1; ex_inh_en = 0;
        wr(1, 64'hC000_0000_0000_0000);
        rd(1, v); chk("R5 xi forced", v, 64'h8000_0000_0000_0000);
        ex_inh_en = 1;
    endtask

    task automatic t_lpa();
        logic [63:0] v;
        wr(0, 64'h0055_5555_4000_0002);
        lpa_en = 0; #1;
        rd(0, v); chk("R6 read zero", v, 64'h0000_0000_0000_0002);
        chk("R6 tlbw zero", tlbw_even & EXT_M, 0);
        wr(0, 64'h002A_AAAA_8000_0004);
        rd(0, v); chk("R6 still zero", v, 64'h0000_0000_0000_0004);
        lpa_en = 1; #1;
        rd(0, v); chk("R6 ext held", v, 64'h0055_5555_4000_0004);
    endtask

    task automatic t_glob();
        wr(0, 64'h1); wr(1, 64'h1);
        #1; chk("R8 and 1", 64'(tlbw_glob), 1);
        chk("R8 bundle odd", tlbw_odd, 64'h1);
        wr(1, 64'h2);
        #1; chk("R8 and 0", 64'(tlbw_glob), 0);
    endtask

    task automatic t_load();
        logic [63:0] v;
        @(negedge clk);
        tlbr_load = 1; tlbr_glob = 1;
        tlbr_even = 64'hFFFF_FFFF_FFFF_FFFE; tlbr_odd = 64'h0000_0000_0000_00AA;
        @(negedge clk); tlbr_load = 0;
        rd(0, v); chk("R9 even", v, ~FILL_M);
        rd(1, v); chk("R9 odd glob", v, 64'h0000_0000_0000_00AB);
        chk("R9 merged glob", 64'(tlbw_glob), 1);
    endtask

    task automatic t_collide();
        logic [63:0] v;
        @(negedge clk);
        tlbr_load = 1; tlbr_glob = 0;
        tlbr_even = 64'h0000_0000_0000_0F00; tlbr_odd = 64'h0000_0000_0000_0F01;
        sw_we = 1; sw_sel = 0; sw_wdata = 64'h0000_0000_0000_00FF;
        @(negedge clk); tlbr_load = 0; sw_we = 0;
        rd(0, v); chk("R10 even load wins", v, 64'h0000_0000_0000_0F00);
        rd(1, v); chk("R10 odd", v, 64'h0000_0000_0000_0F00);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_select();
        t_inhibit();
        t_lpa();
        t_glob();
        t_load();
        t_collide();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule